// File: doc/BRIEF.md
# Stream-Join Sparse Dot-Product Unit

This unit multiplies two sparse rows held in compressed form, where each row is a list of (position, value) pairs sorted by ascending position. Each row arrives on its own valid/ready channel that carries one element per transfer: a column position, a signed value and a flag marking the row's final element. Every cycle in which both heads are present, the unit compares the two positions. The result of that comparison chooses which heads are consumed and which are held for the next comparison. The order in which the two rows are read therefore depends on their contents.

Only equal positions produce a multiply-accumulate. An unequal comparison consumes the head with the smaller position and contributes nothing. The pair is finished as soon as either row delivers its final element. The sum appears on the result port one cycle later, together with a single-cycle done strobe. Any elements still left in the other row are then accepted and thrown away. Only after that does the unit start comparing the next pair of rows, with the accumulator starting again from zero.

Top module: `sparse_join_dot`

## Requirements
- R1: After synchronous reset, `done` is 0 and `result` is 0.
- R2: In a comparison cycle with both heads valid and equal positions, both `a_ready` and `b_ready` are 1, and the product of the two values is added to the running sum.
- R3: In a comparison cycle with both heads valid and `a_idx < b_idx` (unsigned), only `a_ready` is 1. The row B head is held unchanged for the next comparison and adds nothing to the sum.
- R4: In a comparison cycle with both heads valid and `b_idx < a_idx`, only `b_ready` is 1. The row A head is held and adds nothing to the sum.
- R5: While comparing, if either head is not valid, both readies are 0 and no state changes.
- R6: When an element with its last flag set is accepted during comparison, `done` is 1 in the following cycle only, and `result` then equals the sum of products over all positions present in both rows.
- R7: After one row ends, the remaining elements of the other row are accepted (ready is 1) until its last-flagged element, and they do not affect any result. Meanwhile the ended row's ready stays 0.
- R8: Every row pair starts its sum from zero, so a result never includes products from an earlier pair.
- R9: Values are two's-complement signed. Products and the sum wrap modulo 2^32.
- R10: `result` holds its value in every cycle in which `done` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| a_valid | input | 1 | Row A head element present |
| a_ready | output | 1 | Row A head consumed this cycle |
| a_idx | input | 8 | Row A column position |
| a_val | input | 16 | Row A signed value |
| a_last | input | 1 | Row A final element flag |
| b_valid | input | 1 | Row B head element present |
| b_ready | output | 1 | Row B head consumed this cycle |
| b_idx | input | 8 | Row B column position |
| b_val | input | 16 | Row B signed value |
| b_last | input | 1 | Row B final element flag |
| result | output | 32 | Signed dot product of the last finished pair |
| done | output | 1 | One-cycle strobe: result is new |

## Verification
Two events can fall in the same cycle: the done strobe of one pair and the first comparison of the next pair. When both rows end on a shared final position, the unit is comparing the next pair's heads in the very cycle that the previous result is being announced. The sweep provokes this by feeding single-element and matching-tail rows back to back with no gaps. It judges the outcome by requiring every announced result to equal the arithmetic intersection sum of its own pair, and by requiring exactly one done strobe per pair. A directed sequence also makes a drain cycle coincide with the done strobe and checks that the readies are correct in that cycle.

// File: rtl/sj_pkg.sv
package sj_pkg;

    typedef enum logic [1:0] {
        CMP_LT = 2'd0,
        CMP_EQ = 2'd1,
        CMP_GT = 2'd2
    } cmp_e;

    typedef enum logic [1:0] {
        ST_JOIN    = 2'd0,
        ST_DRAIN_A = 2'd1,
        ST_DRAIN_B = 2'd2
    } state_e;

    typedef struct packed {
        logic pop_a;
        logic pop_b;
        logic mac;
    } join_ctl_t;

    function automatic join_ctl_t decode_cmp(input cmp_e c);
        join_ctl_t r;
        r = '0;
        case (c)
            CMP_LT:  r.pop_a = 1'b1;
            CMP_GT:  r.pop_b = 1'b1;
            CMP_EQ:  begin r.pop_a = 1'b1; r.pop_b = 1'b1; r.mac = 1'b1; end
            default: r = '0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/sj_compare.sv
module sj_compare
    import sj_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  logic [IDX_W-1:0] idx_a,
    input  logic [IDX_W-1:0] idx_b,
    output cmp_e             rel
);
    always_comb begin
        if (idx_a == idx_b)     rel = CMP_EQ;
        else if (idx_a < idx_b) rel = CMP_LT;
        else                    rel = CMP_GT;
    end
endmodule

// File: rtl/sj_mac.sv
module sj_mac #(
    parameter int VAL_W = 16,
    parameter int ACC_W = 32
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    clear,
    input  logic                    add,
    input  logic signed [VAL_W-1:0] x,
    input  logic signed [VAL_W-1:0] y,
    output logic signed [ACC_W-1:0] acc_q,
    output logic signed [ACC_W-1:0] acc_next
);
    localparam int EXT_W = ACC_W - VAL_W;

    logic signed [ACC_W-1:0] ext_x, ext_y, prod;

    assign ext_x = {{EXT_W{x[VAL_W-1]}}, x};
    assign ext_y = {{EXT_W{y[VAL_W-1]}}, y};
    assign prod  = ext_x * ext_y;

    always_comb begin
        acc_next = acc_q;
        if (add) acc_next = acc_q + prod;
    end

    always_ff @(posedge clk) begin
        if (rst || clear) acc_q <= '0;
        else              acc_q <= acc_next;
    end
endmodule

// File: rtl/sparse_join_dot.sv
module sparse_join_dot
    import sj_pkg::*;
#(
    parameter int IDX_W = 8,
    parameter int VAL_W = 16,
    parameter int ACC_W = 32
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    a_valid,
    output logic                    a_ready,
    input  logic [IDX_W-1:0]        a_idx,
    input  logic signed [VAL_W-1:0] a_val,
    input  logic                    a_last,
    input  logic                    b_valid,
    output logic                    b_ready,
    input  logic [IDX_W-1:0]        b_idx,
    input  logic signed [VAL_W-1:0] b_val,
    input  logic                    b_last,
    output logic signed [ACC_W-1:0] result,
    output logic                    done
);
    state_e                  state_q, state_d;
    cmp_e                    rel;
    join_ctl_t               ctl;
    logic                    both_v, mac_en;
    logic                    a_end, b_end, term;
    logic signed [ACC_W-1:0] acc_q, acc_next;
    logic signed [ACC_W-1:0] result_q;
    logic                    done_q;

    sj_compare #(.IDX_W(IDX_W)) cmp_i (
        .idx_a (a_idx),
        .idx_b (b_idx),
        .rel   (rel)
    );

    assign ctl    = decode_cmp(rel);
    assign both_v = a_valid && b_valid;

    always_comb begin
        a_ready = 1'b0;
        b_ready = 1'b0;
        mac_en  = 1'b0;
        case (state_q)
            ST_JOIN: begin
                a_ready = both_v && ctl.pop_a;
                b_ready = both_v && ctl.pop_b;
                mac_en  = both_v && ctl.mac;
            end
            ST_DRAIN_A: a_ready = 1'b1;
            ST_DRAIN_B: b_ready = 1'b1;
            default: ;
        endcase
    end

    assign a_end = a_valid && a_ready && a_last;
    assign b_end = b_valid && b_ready && b_last;
    assign term  = (state_q == ST_JOIN) && (a_end || b_end);

    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_JOIN: begin
                if (a_end && !b_end)      state_d = ST_DRAIN_B;
                else if (b_end && !a_end) state_d = ST_DRAIN_A;
            end
            ST_DRAIN_A: if (a_end) state_d = ST_JOIN;
            ST_DRAIN_B: if (b_end) state_d = ST_JOIN;
            default: state_d = ST_JOIN;
        endcase
    end

    sj_mac #(.VAL_W(VAL_W), .ACC_W(ACC_W)) mac_i (
        .clk      (clk),
        .rst      (rst),
        .clear    (term),
        .add      (mac_en),
        .x        (a_val),
        .y        (b_val),
        .acc_q    (acc_q),
        .acc_next (acc_next)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_JOIN;
            result_q <= '0;
            done_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            done_q  <= term;
            if (term) result_q <= acc_next;
        end
    end

    assign result = result_q;
    assign done   = done_q;

    // Both heads consumed while comparing only when positions agree
    assert_match_pop_R2: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_JOIN && a_ready && b_ready) |-> (a_idx == b_idx));

    assert_smaller_a_R3: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_JOIN && a_ready && !b_ready) |-> (a_idx < b_idx));

    assert_smaller_b_R4: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_JOIN && b_ready && !a_ready) |-> (b_idx < a_idx));

    assert_stall_R5: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_JOIN && !both_v) |=> ($stable(acc_q) && !done));

    assert_drain_R7: assert property (@(posedge clk) disable iff (rst)
        (state_q != ST_JOIN) |-> !(a_ready && b_ready));

    assert_fresh_acc_R8: assert property (@(posedge clk) disable iff (rst)
        done |-> (acc_q == '0 || $past(mac_en)));

    assert_hold_result_R10: assert property (@(posedge clk) disable iff (rst)
        !done |-> $stable(result));
endmodule

// File: tb/sparse_join_dot_tb_top.sv
module sparse_join_dot_tb_top;
    localparam int NP    = 225;   // sweep pairs; pair NP is the wrap pair
    localparam int LIMIT = 100000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic a_valid = 0, b_valid = 0, a_last = 0, b_last = 0;
    logic [7:0] a_idx = 0, b_idx = 0;
    logic signed [15:0] a_val = 0, b_val = 0;
    logic a_ready, b_ready, done;
    logic signed [31:0] result;

    int n_chk = 0, n_bad = 0, n_seen = 0, cyc = 0;
    bit sweep_on = 0;

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    sparse_join_dot dut_i (
        .clk(clk), .rst(rst),
        .a_valid(a_valid), .a_ready(a_ready), .a_idx(a_idx), .a_val(a_val), .a_last(a_last),
        .b_valid(b_valid), .b_ready(b_ready), .b_idx(b_idx), .b_val(b_val), .b_last(b_last),
        .result(result), .done(done)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, $signed(act), $signed(exp));
        end
    endtask

    function automatic int mask_a(input int p); return (p == NP) ? 15 : p / 15 + 1; endfunction
    function automatic int mask_b(input int p); return (p == NP) ? 15 : p % 15 + 1; endfunction
    function automatic int va(input int p, input int k);
        return (p == NP) ? 32767 : ((p * 7 + k * 13) % 41) - 20;
    endfunction
    function automatic int vb(input int p, input int k);
        return (p == NP) ? 32767 : ((p * 11 + k * 5) % 37) - 18;
    endfunction
    function automatic logic [31:0] expect_sum(input int p);
        logic [31:0] s = 0;
        for (int k = 0; k < 4; k++)
            if (((mask_a(p) & mask_b(p)) >> k) & 1) s = s + 32'(va(p, k) * vb(p, k));
        return s;
    endfunction

    // Row feeders: position = 3k+1 for each set mask bit k
    initial begin
        wait (sweep_on);
        for (int p = 0; p <= NP; p++)
            for (int k = 0; k < 4; k++)
                if ((mask_a(p) >> k) & 1) begin
                    @(negedge clk); a_valid = 0;
                    repeat ($urandom_range(0, 2)) @(negedge clk);
                    a_valid = 1; a_idx = 8'(3 * k + 1); a_val = 16'(va(p, k));
                    a_last = ((mask_a(p) >> (k + 1)) == 0);
                    forever begin #1; if (a_ready) break; @(negedge clk); end
                    @(posedge clk);
                end
        @(negedge clk); a_valid = 0;
    end

    initial begin
        wait (sweep_on);
        for (int p = 0; p <= NP; p++)
            for (int k = 0; k < 4; k++)
                if ((mask_b(p) >> k) & 1) begin
                    @(negedge clk); b_valid = 0;
                    repeat ($urandom_range(0, 2)) @(negedge clk);
                    b_valid = 1; b_idx = 8'(3 * k + 1); b_val = 16'(vb(p, k));
                    b_last = ((mask_b(p) >> (k + 1)) == 0);
                    forever begin #1; if (b_ready) break; @(negedge clk); end
                    @(posedge clk);
                end
        @(negedge clk); b_valid = 0;
    end

    // Result monitor: every pair's strobe carries its intersection sum (R6, R7, R8, R9)
    always @(negedge clk) begin
        if (sweep_on && done) begin
            if (n_seen <= NP) chk(n_seen == NP ? "R9 wrap sum" : "R6/R7/R8 pair sum",
                                  result, expect_sum(n_seen));
            else chk("R6 extra done", 1, 0);
            n_seen++;
        end
    end

    task automatic drive(input logic av, input int ai, input int aval, input logic al,
                         input logic bv, input int bi, input int bval, input logic bl);
        @(negedge clk);
        a_valid = av; a_idx = 8'(ai); a_val = 16'(aval); a_last = al;
        b_valid = bv; b_idx = 8'(bi); b_val = 16'(bval); b_last = bl;
        #1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        #1;
        chk("R1 done", done, 0);
        chk("R1 result", result, 0);

        drive(1, 2, 7, 0, 0, 0, 0, 0);
        chk("R5 a_ready", a_ready, 0);
        chk("R5 b_ready", b_ready, 0);
        repeat (3) @(negedge clk);
        chk("R5 no done", done, 0);

        drive(1, 2, 7, 0, 1, 5, 4, 0);
        chk("R3 a_ready", a_ready, 1);
        chk("R3 b_ready", b_ready, 0);

        drive(1, 5, 3, 0, 1, 5, 4, 0);
        chk("R2 both ready", {a_ready, b_ready}, 2'b11);

        drive(1, 9, 2, 1, 1, 6, 1, 0);
        chk("R4 a_ready", a_ready, 0);
        chk("R4 b_ready", b_ready, 1);

        drive(1, 9, 2, 1, 1, 9, 10, 0);
        chk("R2 match ready", {a_ready, b_ready}, 2'b11);

        drive(1, 0, -3, 1, 1, 11, 99, 1);
        chk("R6 done pulse", done, 1);
        chk("R6 result", result, 32);
        chk("R7 drain a_ready", a_ready, 0);
        chk("R7 drain b_ready", b_ready, 1);

        drive(1, 0, -3, 1, 1, 0, 5, 1);
        chk("R6 single pulse", done, 0);
        chk("R10 hold", result, 32);
        chk("R2 new pair ready", {a_ready, b_ready}, 2'b11);

        drive(0, 0, 0, 0, 0, 0, 0, 0);
        chk("R8 fresh sum", result, -15);
        chk("R8 done", done, 1);
        @(negedge clk);
        chk("R10 hold after", result, -15);

        sweep_on = 1;
        while (n_seen <= NP && cyc < LIMIT) @(negedge clk);
        if (cyc >= LIMIT) chk("watchdog", n_seen, NP + 1);
        repeat (20) @(negedge clk);
        chk("R6 pulse count", n_seen, NP + 1);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule